// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a FIFO's storage and turns the FIFO's fill count into two active-low threshold flags. One flag warns that few words remain to be read. The other warns that few free locations remain to be written. Each flag compares against its own offset register: the empty offset for the first flag and the full offset for the second.

A full reset sets up the unit. The default select pair and the load pin, sampled while full reset is held, pick one of eight default offsets. Both registers receive that default. The load pin also fixes the programming method. The parity-placement pin, sampled at the same time, fixes how an offset is packed on the data bus.

After reset, software or a neighbouring controller can reprogram the offsets. In serial mode this is done one bit at a time. In parallel mode it is done through the write data bus. In either mode the offsets can be read back through the read data bus. A partial reset restarts the access sequencing but keeps the offsets and every mode chosen at full reset. All ports are sampled on one clock. Any domain crossing is done upstream.

Top module: `pff_flag_unit`

## Requirements
- R1: While `rst_n` is low, both offsets load the default value 2^(i+3)-1, where i = {ld, dflt_sel[1], dflt_sel[0]} (i = 0 gives 7, i = 7 gives 1023). In the same cycles, `almost_empty_n` is driven to 0, `almost_full_n` to 1, and `rd_vld` to 0.
- R2: The method is serial if `ld` is 1 during full reset and parallel if `ld` is 0. The parity placement is interspersed if `ip_sel` is 1 during full reset. Both choices hold until the next full reset.
- R3: One cycle after `fill_cnt` is sampled, `almost_empty_n` is 1 if `fill_cnt` >= the empty offset and 0 otherwise.
- R4: One cycle after `fill_cnt` is sampled, `almost_full_n` is 1 if DEPTH - `fill_cnt` > the full offset and 0 otherwise.
- R5: In parallel mode, a cycle with `wr_en` and `ld` both high writes the offset taken from `wr_data` into the register chosen by a shared toggle. The toggle selects the empty offset when 0 and the full offset when 1, and it flips after each access. The same cycle must not also have `rd_en` high.
- R6: A cycle with `rd_en` and `ld` both high makes `rd_vld` high in the next cycle. In that cycle `rd_data` carries the offset chosen by the shared toggle, and the toggle flips. This works in both methods.
- R7: In serial mode, a cycle with `ser_en` and `ld` both high shifts `ser_bit` in, most significant bit first. The first OFS_W shifts fill the empty offset and the next OFS_W shifts fill the full offset. After 2*OFS_W shifts the sequence wraps.
- R8: Serial shifts have no effect in parallel mode. Parallel writes have no effect in serial mode, and such a write does not move the toggle.
- R9: In interspersed placement, bus bits 8, 17, 26 and 35 are skipped. Offset bit k maps to bus bit k + k/8 when writing, and readback uses the same mapping with the skipped bits read as 0. In non-interspersed placement, offset bit k maps to bus bit k, so bits 32 to 35 never carry offset data.
- R10: While `prst_n` is low (and `rst_n` is high), the toggle and the serial bit position return to their start. The offsets, method and placement are kept, and no load or readback happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every port |
| rst_n | input | 1 | Full reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| dflt_sel | input | 2 | Default offset select, sampled during full reset |
| ip_sel | input | 1 | Parity placement select, sampled during full reset |
| ld | input | 1 | Method select during full reset; offset access enable afterwards |
| wr_en | input | 1 | Write strobe for parallel offset loading |
| wr_data | input | BUS_W | Write data bus |
| rd_en | input | 1 | Read strobe for offset readback |
| rd_vld | output | 1 | Readback data valid |
| rd_data | output | BUS_W | Readback data bus |
| ser_en | input | 1 | Serial shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| fill_cnt | input | CNT_W | Current FIFO word count, 0 to DEPTH |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume four things about the inputs:
- a parallel write and a readback never share a cycle;
- `fill_cnt` never exceeds DEPTH;
- `ld`, `dflt_sel` and `ip_sel` have settled during full reset;
- the count input is only meaningful once full reset has been released.

The stimulus respects these assumptions. Every access strobe is one cycle wide and is driven on the falling edge. Reads and writes are always placed in separate cycles. Count values are limited to 0 to DEPTH. Each full reset is held for several cycles with its configuration pins steady.

// File: rtl/pff_pkg.sv
package pff_pkg;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    localparam int NUM_DFLT = 8;

    // Default offset for table index idx: 2^(idx+3) - 1.
    function automatic logic [31:0] dflt_offset(input logic [2:0] idx);
        logic [31:0] sh;
        sh = {29'd0, idx} + 32'd3;
        return (32'd1 << sh) - 32'd1;
    endfunction

endpackage

// File: rtl/pff_bus_map.sv
module pff_bus_map #(
    parameter int BUS_W = 36,
    parameter int OFS_W = 10
) (
    input  logic             ip_mode,
    input  logic [BUS_W-1:0] bus_in,
    output logic [OFS_W-1:0] ofs_out,
    input  logic [OFS_W-1:0] ofs_in,
    output logic [BUS_W-1:0] bus_out
);
    // Interspersed placement skips one bit after each group of eight.
    localparam int GRP = 8;

    logic [OFS_W-1:0] ofs_il;
    logic [OFS_W-1:0] ofs_nl;

    for (genvar k = 0; k < OFS_W; k++) begin : g_ext
        localparam int PK = k + k / GRP;
        assign ofs_il[k] = bus_in[PK];
        assign ofs_nl[k] = bus_in[k];
    end

    assign ofs_out = ip_mode ? ofs_il : ofs_nl;

    always_comb begin
        bus_out = '0;
        for (int k = 0; k < OFS_W; k++) begin
            if (ip_mode) begin
                bus_out[k + k / GRP] = ofs_in[k];
            end else begin
                bus_out[k] = ofs_in[k];
            end
        end
    end

endmodule

// File: rtl/pff_offset_regs.sv
module pff_offset_regs
    import pff_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic [1:0]       dflt_sel,
    input  logic             ip_sel,
    input  logic             ld,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic             rd_en,
    input  logic             ser_en,
    input  logic             ser_bit,
    output logic [OFS_W-1:0] ofs_e,
    output logic [OFS_W-1:0] ofs_f,
    output logic             ip_mode,
    output logic             rd_vld,
    output logic [OFS_W-1:0] rd_ofs
);
    localparam int              SB_W    = $clog2(2 * OFS_W);
    localparam logic [SB_W-1:0] SB_HALF = SB_W'(OFS_W);
    localparam logic [SB_W-1:0] SB_LAST = SB_W'(2 * OFS_W - 1);

    typedef struct packed {
        logic [OFS_W-1:0] ofs_e;
        logic [OFS_W-1:0] ofs_f;
        logic             tgl;
        logic [SB_W-1:0]  sbit;
        load_mode_e       mode;
        logic             ip;
        logic             rd_vld;
        logic [OFS_W-1:0] rd_ofs;
    } st_t;

    st_t st_d, st_q;

    logic             par_wr;
    logic             rb_req;
    logic             ser_sh;
    logic [OFS_W-1:0] dflt_val;

    assign par_wr   = wr_en & ld & (st_q.mode == LOAD_PAR);
    assign rb_req   = rd_en & ld;
    assign ser_sh   = ser_en & ld & (st_q.mode == LOAD_SER);
    assign dflt_val = OFS_W'(dflt_offset({ld, dflt_sel}));

    always_comb begin
        st_d        = st_q;
        st_d.rd_vld = 1'b0;
        if (!rst_n) begin
            st_d.ofs_e  = dflt_val;
            st_d.ofs_f  = dflt_val;
            st_d.tgl    = 1'b0;
            st_d.sbit   = '0;
            st_d.mode   = ld ? LOAD_SER : LOAD_PAR;
            st_d.ip     = ip_sel;
            st_d.rd_ofs = '0;
        end else if (!prst_n) begin
            st_d.tgl  = 1'b0;
            st_d.sbit = '0;
        end else begin
            if (ser_sh) begin
                if (st_q.sbit < SB_HALF) begin
                    st_d.ofs_e = OFS_W'({st_q.ofs_e, ser_bit});
                end else begin
                    st_d.ofs_f = OFS_W'({st_q.ofs_f, ser_bit});
                end
                st_d.sbit = (st_q.sbit == SB_LAST) ? '0 : st_q.sbit + 1'b1;
            end
            if (par_wr) begin
                if (!st_q.tgl) begin
                    st_d.ofs_e = wr_ofs;
                end else begin
                    st_d.ofs_f = wr_ofs;
                end
                st_d.tgl = ~st_q.tgl;
            end else if (rb_req) begin
                st_d.rd_vld = 1'b1;
                st_d.rd_ofs = st_q.tgl ? st_q.ofs_f : st_q.ofs_e;
                st_d.tgl    = ~st_q.tgl;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ofs_e   = st_q.ofs_e;
    assign ofs_f   = st_q.ofs_f;
    assign ip_mode = st_q.ip;
    assign rd_vld  = st_q.rd_vld;
    assign rd_ofs  = st_q.rd_ofs;

    // Input rule: write load and readback never share a cycle (R5).
    p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld && wr_en && rd_en));

    // Readback request yields valid data next cycle (R6).
    p_rb_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && ld && rd_en) |=> rd_vld);

    // Serial bit position stays inside its two-register window (R7).
    p_sbit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sbit <= SB_LAST);

    // Serial shifts leave offsets alone in parallel mode (R8).
    p_ser_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LOAD_PAR && ld && ser_en && !wr_en)
        |=> ($stable(ofs_e) && $stable(ofs_f)));

    // Parallel writes leave offsets alone in serial mode (R8).
    p_par_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LOAD_SER && ld && wr_en && !ser_en)
        |=> ($stable(ofs_e) && $stable(ofs_f)));

    // Partial reset keeps both offsets (R10).
    p_prst_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> ($stable(ofs_e) && $stable(ofs_f) && !rd_vld));

endmodule

// File: rtl/pff_flag_cmp.sv
module pff_flag_cmp #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11,
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [OFS_W-1:0] ofs_e,
    input  logic [OFS_W-1:0] ofs_f,
    output logic             ae_n,
    output logic             af_n
);
    localparam int CMP_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;

    typedef struct packed {
        logic ae_n;
        logic af_n;
    } fl_t;

    fl_t fl_d, fl_q;

    logic [CMP_W-1:0] cnt_w;
    logic [CMP_W-1:0] free_w;

    assign cnt_w  = CMP_W'(fill_cnt);
    assign free_w = CMP_W'(DEPTH) - cnt_w;

    always_comb begin
        fl_d = fl_q;
        if (!rst_n) begin
            fl_d.ae_n = 1'b0;
            fl_d.af_n = 1'b1;
        end else begin
            fl_d.ae_n = (cnt_w >= CMP_W'(ofs_e));
            fl_d.af_n = (free_w > CMP_W'(ofs_f));
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign ae_n = fl_q.ae_n;
    assign af_n = fl_q.af_n;

    // An empty FIFO with a nonzero empty offset reads as almost empty (R3).
    p_empty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_cnt) == '0 && $past(ofs_e) != '0) |-> !ae_n);

    // A full FIFO always reads as almost full (R4).
    p_full_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_cnt) == CNT_W'(DEPTH)) |-> !af_n);

    // An empty FIFO is not almost full while the full offset is below DEPTH (R4).
    p_drained_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_cnt) == '0 && int'($past(ofs_f)) < DEPTH) |-> af_n);

endmodule

// File: rtl/pff_flag_unit.sv
module pff_flag_unit
    import pff_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int OFS_W = 10,
    parameter int BUS_W = 36,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic [1:0]       dflt_sel,
    input  logic             ip_sel,
    input  logic             ld,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_en,
    output logic             rd_vld,
    output logic [BUS_W-1:0] rd_data,
    input  logic             ser_en,
    input  logic             ser_bit,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             almost_empty_n,
    output logic             almost_full_n
);
    logic [OFS_W-1:0] wr_ofs;
    logic [OFS_W-1:0] rd_ofs;
    logic [OFS_W-1:0] ofs_e;
    logic [OFS_W-1:0] ofs_f;
    logic             ip_mode;

    pff_bus_map #(
        .BUS_W (BUS_W),
        .OFS_W (OFS_W)
    ) u_map (
        .ip_mode (ip_mode),
        .bus_in  (wr_data),
        .ofs_out (wr_ofs),
        .ofs_in  (rd_ofs),
        .bus_out (rd_data)
    );

    pff_offset_regs #(
        .OFS_W (OFS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .prst_n   (prst_n),
        .dflt_sel (dflt_sel),
        .ip_sel   (ip_sel),
        .ld       (ld),
        .wr_en    (wr_en),
        .wr_ofs   (wr_ofs),
        .rd_en    (rd_en),
        .ser_en   (ser_en),
        .ser_bit  (ser_bit),
        .ofs_e    (ofs_e),
        .ofs_f    (ofs_f),
        .ip_mode  (ip_mode),
        .rd_vld   (rd_vld),
        .rd_ofs   (rd_ofs)
    );

    pff_flag_cmp #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .OFS_W (OFS_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_cnt (fill_cnt),
        .ofs_e    (ofs_e),
        .ofs_f    (ofs_f),
        .ae_n     (almost_empty_n),
        .af_n     (almost_full_n)
    );

    // The count input never exceeds the FIFO depth (R4).
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_cnt) <= DEPTH);

endmodule

// File: tb/sim_pff_flag_unit.sv
module sim_pff_flag_unit;
    localparam int DEPTH = 1024;
    localparam int OFS_W = 10;
    localparam int BUS_W = 36;
    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prst_n = 1'b1;
    logic [1:0]       dflt_sel = 2'b11;
    logic             ip_sel = 1'b0;
    logic             ld = 1'b0;
    logic             wr_en = 1'b0;
    logic [BUS_W-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic             rd_vld;
    logic [BUS_W-1:0] rd_data;
    logic             ser_en = 1'b0;
    logic             ser_bit = 1'b0;
    logic [CNT_W-1:0] fill_cnt = '0;
    logic             almost_empty_n;
    logic             almost_full_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [BUS_W-1:0] exp_q[$];
    string            tag_q[$];

    always #10 clk = ~clk;

    pff_flag_unit #(
        .DEPTH (DEPTH),
        .OFS_W (OFS_W),
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .prst_n         (prst_n),
        .dflt_sel       (dflt_sel),
        .ip_sel         (ip_sel),
        .ld             (ld),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_en          (rd_en),
        .rd_vld         (rd_vld),
        .rd_data        (rd_data),
        .ser_en         (ser_en),
        .ser_bit        (ser_bit),
        .fill_cnt       (fill_cnt),
        .almost_empty_n (almost_empty_n),
        .almost_full_n  (almost_full_n)
    );

    // Interspersed placement: bus positions 8, 17, 26, 35 carry no offset bits.
    function automatic logic [BUS_W-1:0] spread(input logic [OFS_W-1:0] v);
        logic [BUS_W-1:0] b;
        int k;
        b = '0;
        k = 0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i != 8 && i != 17 && i != 26 && i != 35) begin
                if (k < OFS_W) b[i] = v[k];
                k++;
            end
        end
        return b;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pop one expected item per valid readback.
    always @(negedge clk) begin
        if (rst_n && rd_vld === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected readback", 64'(rd_data), 64'hDEAD);
            end else begin
                check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic do_reset(input logic l, input logic [1:0] s, input logic ip);
        @(negedge clk);
        rst_n = 1'b0; ld = l; dflt_sel = s; ip_sel = ip;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; ld = 1'b0;
    endtask

    task automatic pwrite(input logic [BUS_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; ld = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; ld = 1'b0;
    endtask

    task automatic readback(input logic [BUS_W-1:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b1; ld = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; ld = 1'b0;
    endtask

    task automatic sshift(input logic [2*OFS_W-1:0] w, input int nbits);
        for (int i = 2*OFS_W-1; i > 2*OFS_W-1-nbits; i--) begin
            @(negedge clk);
            ser_en = 1'b1; ld = 1'b1; ser_bit = w[i];
        end
        @(negedge clk);
        ser_en = 1'b0; ld = 1'b0;
    endtask

    task automatic pulse_prst();
        @(negedge clk);
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
    endtask

    task automatic flag_chk(input int cnt, input logic ae, input logic af, input string tag);
        @(negedge clk);
        fill_cnt = CNT_W'(cnt);
        @(negedge clk);
        check({tag, " empty flag"}, 64'(almost_empty_n), 64'(ae));
        check({tag, " full flag"}, 64'(almost_full_n), 64'(af));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Phase A: parallel, non-interspersed, default index 3 -> 63.
        do_reset(1'b0, 2'b11, 1'b0);
        @(negedge clk);
        check("R1 reset empty flag", 64'(almost_empty_n), 64'd0);
        check("R1 reset full flag", 64'(almost_full_n), 64'd1);
        check("R1 reset valid", 64'(rd_vld), 64'd0);
        readback(36'd63, "R1 default empty offset");
        readback(36'd63, "R1 default full offset");
        flag_chk(62, 1'b0, 1'b1, "R3 below empty offset");
        flag_chk(63, 1'b1, 1'b1, "R3 at empty offset");
        flag_chk(961, 1'b1, 1'b0, "R4 free equals full offset");
        flag_chk(960, 1'b1, 1'b1, "R4 free above full offset");
        flag_chk(1024, 1'b1, 1'b0, "R4 full");
        pwrite(36'd100);
        pwrite(36'd900);
        readback(36'd100, "R5 parallel empty offset");
        readback(36'd900, "R5 parallel full offset");
        pwrite(36'hF_0000_0005);
        pwrite(36'h0_0000_0123);
        readback(36'd5, "R9 non-interspersed empty offset");
        readback(36'h123, "R9 non-interspersed full offset");
        sshift(20'hFFFFF, 20);
        readback(36'd5, "R8 serial ignored empty");
        readback(36'h123, "R8 serial ignored full");
        flag_chk(4, 1'b0, 1'b1, "R3 new offset below");
        flag_chk(5, 1'b1, 1'b1, "R3 new offset at");
        flag_chk(733, 1'b1, 1'b0, "R4 new offset at");
        flag_chk(732, 1'b1, 1'b1, "R4 new offset above");
        pwrite(36'd7);
        pulse_prst();
        readback(36'd7, "R10 toggle restart empty");
        readback(36'h123, "R10 kept full offset");

        // Phase B: serial, interspersed, default index 5 -> 255.
        do_reset(1'b1, 2'b01, 1'b1);
        readback(spread(10'd255), "R2 serial default empty");
        readback(spread(10'd255), "R2 serial default full");
        pwrite(36'd3);
        readback(spread(10'd255), "R8 parallel ignored empty");
        readback(spread(10'd255), "R8 parallel ignored full");
        sshift({10'h155, 10'h2AA}, 20);
        readback(spread(10'h155), "R7 serial empty offset");
        readback(spread(10'h2AA), "R7 serial full offset");
        sshift(20'hFFFFF, 3);
        pulse_prst();
        sshift({10'h0F0, 10'h00F}, 20);
        readback(spread(10'h0F0), "R10 serial restart empty");
        readback(spread(10'h00F), "R10 serial restart full");
        flag_chk(239, 1'b0, 1'b1, "R3 serial offset below");
        flag_chk(240, 1'b1, 1'b1, "R3 serial offset at");

        // Phase C: parallel, interspersed, default index 0 -> 7.
        do_reset(1'b0, 2'b00, 1'b1);
        readback(spread(10'd7), "R1 smallest default");
        readback(spread(10'd7), "R1 smallest default full");
        pwrite(spread(10'h3C5) | 36'h8_0402_0100);
        pwrite(spread(10'h011));
        readback(spread(10'h3C5), "R9 interspersed empty offset");
        readback(spread(10'h011), "R9 interspersed full offset");

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule